// File: doc/BRIEF.md
# Keypad Controller Command Decoder

This block decodes commands for a keypad and GPIO controller that sits behind a byte-wide serial slave. The slave front end, which is not part of this block, reports three kinds of event. The first is a start-of-transaction pulse with a direction flag. The second is a byte written by the host. The third is a request for a byte to return to the host. After a start in the write direction, the first written byte selects a command. Any further bytes are parameters, counted from zero. A read transaction returns response bytes for the command that is currently selected, counted from zero from its own start.

The block holds the settings that the rest of the controller uses: configuration, active time, debounce, keypad size, clock setting, and three 16-bit GPIO registers (pull, direction, state). It also holds the interrupt status byte and a sticky error byte, and it drives an active-low interrupt. Parameters that fall outside their legal range set sticky error flags. A software reset takes effect only when it carries a key byte. Writing the configuration pulses a flush request to the key event queue, which is outside this block.

Top module: `kpc_cmd_ctrl`

## Requirements
- R1: After hardware reset the registers hold these values: config 0x80, active time 125, debounce 3, keypad size 0x33, clock 0x08, all three GPIO registers 0, error 0, and status 0x10 (bit 4 = not initialised). Because status is non-zero, irq_n is low.
- R2: The first byte written after a start in the write direction selects the command. The accepted codes are 0x80 to 0x88, 0x8B, 0x8C, 0x8F and 0x90 to 0x94. Any other code sets error bit 1. A parameter written to a read-only command, or a read of a write-only command, also sets error bit 1, and such a read returns 0x00.
- R3: Command 0x80 returns 0x00, then 0x04, then 0x00 for every later byte of the read.
- R4: Commands 0x84 (pull), 0x85 (direction) and 0x86 (state) take the low byte first, which also clears the high byte, and then the high byte. The command completes on the second byte. Commands 0x87 and 0x88 return direction and state, low byte first.
- R5: Command 0x82 returns the status byte and then clears it to 0. When status bit 4 is set, the byte is returned and status is left unchanged.
- R6: Command 0x81 stores the config byte, clears status and raises queue_flush for one cycle. Command 0x92 returns only bits 3:0 of config.
- R7: In command 0x90, bits 3:0 are the rows (legal range 3..12) and bits 7:4 are the columns (legal range 3..8). An illegal value sets error bit 0 but is still stored. Command 0x91 returns the stored value.
- R8: Command 0x8F with value 0 sets error bit 0. Command 0x93 sets error bit 0 when bits 1:0 are 01 or 10. In both cases the value is stored. Command 0x94 returns the clock value with bits 1:0 forced to 10.
- R9: Command 0x83 with parameter 0xAA restores the R1 values of config, active time, debounce, keypad size and clock, and sets status to 0x10. GPIO and error are kept. Any other parameter sets error bit 0 and changes nothing else.
- R10: A parameter byte written after the command has completed, or with no command selected since hardware reset, sets error bit 0.
- R11: Error bits clear only on hardware reset. Command 0x8C returns the error byte. Whenever an error bit is set, status bit 3 is set in the same cycle.
- R12: irq_n is low exactly when the status byte is non-zero, with no added delay.
- R13: rd_data and rd_valid are registered: the cycle after a read request, rd_valid is high and rd_data holds the response byte.
- R14: Command 0x8B stores any value as the active time without an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_start | input | 1 | Start of a transaction (one-cycle pulse) |
| txn_write | input | 1 | Direction of the starting transaction, 1 = host writes |
| wr_valid | input | 1 | Written byte present |
| wr_data | input | 8 | Written byte |
| rd_req | input | 1 | Request for one response byte |
| rd_data | output | 8 | Response byte |
| rd_valid | output | 1 | rd_data updated this cycle |
| irq_n | output | 1 | Active-low interrupt |
| cfg_o | output | 8 | Configuration register |
| act_time_o | output | 8 | Active time |
| debounce_o | output | 8 | Debounce time |
| kp_size_o | output | 8 | Keypad size: bits 7:4 = columns, bits 3:0 = rows |
| clk_cfg_o | output | 8 | Clock setting |
| gpio_pull_o | output | 16 | GPIO pull select |
| gpio_dir_o | output | 16 | GPIO direction |
| gpio_state_o | output | 16 | GPIO state |
| queue_flush | output | 1 | One-cycle request to empty the key event queue |

## Verification
The hardest case to reach from the ports is a status read that must leave status unchanged. That happens only while the not-initialised flag is set, and that flag is present only after a hardware reset or an accepted software reset, before any config write. The bench reads status twice straight after reset. It repeats this after a software reset issued on top of a set error flag, so that the reset must overwrite a status that already had bit 3 set. Checks on sticky errors and on completed commands require a hardware reset between scenarios, so that each flag comes from its own stimulus.

// File: rtl/kpc_pkg.sv
package kpc_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [7:0] {
    CMD_NONE     = 8'h00,
    CMD_RD_ID    = 8'h80,
    CMD_WR_CFG   = 8'h81,
    CMD_RD_STAT  = 8'h82,
    CMD_SOFT_RST = 8'h83,
    CMD_WR_PULL  = 8'h84,
    CMD_WR_DIR   = 8'h85,
    CMD_WR_STATE = 8'h86,
    CMD_RD_DIR   = 8'h87,
    CMD_RD_STATE = 8'h88,
    CMD_SET_ACT  = 8'h8B,
    CMD_RD_ERR   = 8'h8C,
    CMD_SET_DBN  = 8'h8F,
    CMD_SET_KSZ  = 8'h90,
    CMD_RD_KSZ   = 8'h91,
    CMD_RD_CFG   = 8'h92,
    CMD_WR_CLK   = 8'h93,
    CMD_RD_CLK   = 8'h94
  } cmd_e;

  // bit positions inside the error and status bytes
  localparam int ERR_BADPAR = 0;
  localparam int ERR_UNKCMD = 1;
  localparam int ST_ERROR   = 3;
  localparam int ST_NOINIT  = 4;

  function automatic logic cmd_known(input logic [7:0] c);
    case (c)
      CMD_RD_ID, CMD_WR_CFG, CMD_RD_STAT, CMD_SOFT_RST, CMD_WR_PULL,
      CMD_WR_DIR, CMD_WR_STATE, CMD_RD_DIR, CMD_RD_STATE, CMD_SET_ACT,
      CMD_RD_ERR, CMD_SET_DBN, CMD_SET_KSZ, CMD_RD_KSZ, CMD_RD_CFG,
      CMD_WR_CLK, CMD_RD_CLK: return 1'b1;
      default:                return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/kpc_txn_tracker.sv
module kpc_txn_tracker #(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             txn_start,
  input  logic             txn_write,
  input  logic             wr_valid,
  input  logic [7:0]       wr_data,
  input  logic             rd_req,
  input  logic             par_finish,
  output logic [7:0]       cmd_q,
  output logic [IDX_W-1:0] idx_q,
  output logic             done_q,
  output logic             ev_cap,
  output logic             ev_par,
  output logic             ev_rd
);
  logic arm_q;

  // start has priority, then a written byte, then a read request
  assign ev_cap = !txn_start && wr_valid && arm_q;
  assign ev_par = !txn_start && wr_valid && !arm_q;
  assign ev_rd  = !txn_start && !wr_valid && rd_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q  <= 1'b0;
      idx_q  <= '0;
      cmd_q  <= kpc_pkg::CMD_NONE;
      done_q <= 1'b1;
    end else if (txn_start) begin
      arm_q <= txn_write;
      idx_q <= '0;
    end else if (ev_cap) begin
      arm_q  <= 1'b0;
      idx_q  <= '0;
      cmd_q  <= wr_data;
      done_q <= 1'b0;
    end else if (ev_par || ev_rd) begin
      if (idx_q != {IDX_W{1'b1}}) idx_q <= idx_q + 1'b1;
      if (ev_par && par_finish) done_q <= 1'b1;
    end
  end
endmodule

// File: rtl/kpc_param_check.sv
module kpc_param_check #(
  parameter int         IDX_W      = 2,
  parameter int         GPIO_BYTES = 2,
  parameter int         ROW_MIN    = 3,
  parameter int         ROW_MAX    = 12,
  parameter int         COL_MIN    = 3,
  parameter int         COL_MAX    = 8,
  parameter logic [7:0] RST_KEY    = 8'hAA
) (
  input  logic [7:0]       cmd,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       data,
  input  logic             done,
  output logic             bad,
  output logic             unk,
  output logic             finish
);
  import kpc_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GPIO_BYTES - 1);

  logic [3:0] rows, cols;
  assign rows = data[3:0];
  assign cols = data[7:4];

  always_comb begin
    bad    = 1'b0;
    unk    = 1'b0;
    finish = 1'b0;
    if (done) begin
      bad = 1'b1;
    end else begin
      case (cmd)
        CMD_WR_CFG, CMD_SET_ACT: finish = 1'b1;
        CMD_SET_DBN: begin
          finish = 1'b1;
          bad    = (data == 8'h00);
        end
        CMD_SET_KSZ: begin
          finish = 1'b1;
          bad    = (int'(rows) < ROW_MIN) || (int'(rows) > ROW_MAX) ||
                   (int'(cols) < COL_MIN) || (int'(cols) > COL_MAX);
        end
        CMD_WR_CLK: begin
          finish = 1'b1;
          bad    = data[1] ^ data[0];
        end
        CMD_SOFT_RST: begin
          finish = 1'b1;
          bad    = (data != RST_KEY);
        end
        CMD_WR_PULL, CMD_WR_DIR, CMD_WR_STATE: finish = (idx == LAST_IDX);
        default: unk = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/kpc_ctrl_regs.sv
module kpc_ctrl_regs #(
  parameter int         IDX_W    = 2,
  parameter int         GPIO_W   = 16,
  parameter logic [7:0] CFG_RST  = 8'h80,
  parameter logic [7:0] ACT_RST  = 8'd125,
  parameter logic [7:0] DBN_RST  = 8'd3,
  parameter logic [7:0] KSZ_RST  = 8'h33,
  parameter logic [7:0] CLK_RST  = 8'h08
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_cap,
  input  logic [7:0]        cap_code,
  input  logic              ev_par,
  input  logic [7:0]        cmd,
  input  logic [IDX_W-1:0]  idx,
  input  logic [7:0]        data,
  input  logic              done,
  input  logic              par_bad,
  input  logic              par_unk,
  input  logic              ev_rd,
  input  logic              rd_unk,
  input  logic              rd_clr,
  output logic [7:0]        cfg_q,
  output logic [7:0]        act_q,
  output logic [7:0]        dbn_q,
  output logic [7:0]        ksz_q,
  output logic [7:0]        clk_q,
  output logic [GPIO_W-1:0] pull_q,
  output logic [GPIO_W-1:0] dir_q,
  output logic [GPIO_W-1:0] state_q,
  output logic [7:0]        status_q,
  output logic [7:0]        err_q,
  output logic              irq_n,
  output logic              flush
);
  import kpc_pkg::*;

  localparam int GPIO_BYTES = GPIO_W / 8;
  localparam logic [7:0] ST_RST = 8'(1 << ST_NOINIT);

  logic       wr_ok, cfg_we, srst_ok, any_err;
  logic [7:0] err_set, err_n, st_n;

  function automatic logic [GPIO_W-1:0] gpio_merge(
    input logic [GPIO_W-1:0] old, input logic [IDX_W-1:0] i, input logic [7:0] d);
    logic [GPIO_W-1:0] r;
    r = (i == '0) ? '0 : old;
    for (int b = 0; b < GPIO_BYTES; b++)
      if (i == IDX_W'(b)) r[b*8 +: 8] = d;
    return r;
  endfunction

  assign wr_ok   = ev_par && !done;
  assign cfg_we  = wr_ok && (cmd == CMD_WR_CFG);
  assign srst_ok = wr_ok && (cmd == CMD_SOFT_RST) && !par_bad;

  always_comb begin
    err_set = '0;
    err_set[ERR_BADPAR] = ev_par && par_bad;
    err_set[ERR_UNKCMD] = (ev_cap && !cmd_known(cap_code)) ||
                          (ev_par && par_unk) || (ev_rd && rd_unk);
    any_err = |err_set;
    err_n   = err_q | err_set;

    st_n = status_q;
    if (srst_ok)                            st_n = ST_RST;
    else if (cfg_we)                        st_n = '0;
    else if (rd_clr && !status_q[ST_NOINIT]) st_n = '0;
    if (any_err) st_n[ST_ERROR] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= CFG_RST;
      act_q    <= ACT_RST;
      dbn_q    <= DBN_RST;
      ksz_q    <= KSZ_RST;
      clk_q    <= CLK_RST;
      pull_q   <= '0;
      dir_q    <= '0;
      state_q  <= '0;
      status_q <= ST_RST;
      err_q    <= '0;
      irq_n    <= 1'b0;
      flush    <= 1'b0;
    end else begin
      status_q <= st_n;
      err_q    <= err_n;
      irq_n    <= (st_n == '0);
      flush    <= cfg_we;
      if (srst_ok) begin
        cfg_q <= CFG_RST;
        act_q <= ACT_RST;
        dbn_q <= DBN_RST;
        ksz_q <= KSZ_RST;
        clk_q <= CLK_RST;
      end else if (wr_ok) begin
        case (cmd)
          CMD_WR_CFG:   cfg_q   <= data;
          CMD_SET_ACT:  act_q   <= data;
          CMD_SET_DBN:  dbn_q   <= data;
          CMD_SET_KSZ:  ksz_q   <= data;
          CMD_WR_CLK:   clk_q   <= data;
          CMD_WR_PULL:  pull_q  <= gpio_merge(pull_q, idx, data);
          CMD_WR_DIR:   dir_q   <= gpio_merge(dir_q, idx, data);
          CMD_WR_STATE: state_q <= gpio_merge(state_q, idx, data);
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/kpc_resp.sv
module kpc_resp #(
  parameter int          IDX_W  = 2,
  parameter int          GPIO_W = 16,
  parameter logic [15:0] ID_VAL = 16'h0400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_rd,
  input  logic [7:0]        cmd,
  input  logic [IDX_W-1:0]  idx,
  input  logic [7:0]        cfg_q,
  input  logic [7:0]        ksz_q,
  input  logic [7:0]        clk_q,
  input  logic [GPIO_W-1:0] dir_q,
  input  logic [GPIO_W-1:0] state_q,
  input  logic [7:0]        status_q,
  input  logic [7:0]        err_q,
  output logic              rd_unk,
  output logic              rd_clr,
  output logic [7:0]        rd_data,
  output logic              rd_valid
);
  import kpc_pkg::*;

  logic [7:0]        byte_n;
  logic [GPIO_W-1:0] dir_sh, state_sh;
  logic [15:0]       id_sh;

  assign dir_sh   = dir_q   >> {idx, 3'b000};
  assign state_sh = state_q >> {idx, 3'b000};
  assign id_sh    = ID_VAL  >> {idx, 3'b000};
  assign rd_clr   = ev_rd && (cmd == CMD_RD_STAT);

  always_comb begin
    rd_unk = 1'b0;
    case (cmd)
      CMD_RD_ID:    byte_n = id_sh[7:0];
      CMD_RD_STAT:  byte_n = status_q;
      CMD_RD_DIR:   byte_n = dir_sh[7:0];
      CMD_RD_STATE: byte_n = state_sh[7:0];
      CMD_RD_ERR:   byte_n = err_q;
      CMD_RD_KSZ:   byte_n = ksz_q;
      CMD_RD_CFG:   byte_n = {4'h0, cfg_q[3:0]};
      CMD_RD_CLK:   byte_n = {clk_q[7:2], 2'b10};
      default: begin
        byte_n = 8'h00;
        rd_unk = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= ev_rd;
      if (ev_rd) rd_data <= byte_n;
    end
  end
endmodule

// File: rtl/kpc_cmd_ctrl.sv
module kpc_cmd_ctrl #(
  parameter int          GPIO_W  = 16,
  parameter logic [15:0] ID_VAL  = 16'h0400,
  parameter logic [7:0]  CFG_RST = 8'h80,
  parameter logic [7:0]  ACT_RST = 8'd125,
  parameter logic [7:0]  DBN_RST = 8'd3,
  parameter logic [7:0]  KSZ_RST = 8'h33,
  parameter logic [7:0]  CLK_RST = 8'h08,
  parameter logic [7:0]  RST_KEY = 8'hAA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              txn_start,
  input  logic              txn_write,
  input  logic              wr_valid,
  input  logic [7:0]        wr_data,
  input  logic              rd_req,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              irq_n,
  output logic [7:0]        cfg_o,
  output logic [7:0]        act_time_o,
  output logic [7:0]        debounce_o,
  output logic [7:0]        kp_size_o,
  output logic [7:0]        clk_cfg_o,
  output logic [GPIO_W-1:0] gpio_pull_o,
  output logic [GPIO_W-1:0] gpio_dir_o,
  output logic [GPIO_W-1:0] gpio_state_o,
  output logic              queue_flush
);
  localparam int GPIO_BYTES = GPIO_W / 8;
  localparam int IDX_W      = $clog2(GPIO_BYTES + 2);

  logic [7:0]       cmd_w, status_w, err_w;
  logic [IDX_W-1:0] idx_w;
  logic             done_w, ev_cap, ev_par, ev_rd;
  logic             par_bad, par_unk, par_fin, rd_unk, rd_clr;

  kpc_txn_tracker #(.IDX_W(IDX_W)) u_trk (
    .clk(clk), .rst(rst), .txn_start(txn_start), .txn_write(txn_write),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req),
    .par_finish(par_fin), .cmd_q(cmd_w), .idx_q(idx_w), .done_q(done_w),
    .ev_cap(ev_cap), .ev_par(ev_par), .ev_rd(ev_rd)
  );

  kpc_param_check #(.IDX_W(IDX_W), .GPIO_BYTES(GPIO_BYTES), .RST_KEY(RST_KEY)) u_chkp (
    .cmd(cmd_w), .idx(idx_w), .data(wr_data), .done(done_w),
    .bad(par_bad), .unk(par_unk), .finish(par_fin)
  );

  kpc_ctrl_regs #(
    .IDX_W(IDX_W), .GPIO_W(GPIO_W), .CFG_RST(CFG_RST), .ACT_RST(ACT_RST),
    .DBN_RST(DBN_RST), .KSZ_RST(KSZ_RST), .CLK_RST(CLK_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .ev_cap(ev_cap), .cap_code(wr_data),
    .ev_par(ev_par), .cmd(cmd_w), .idx(idx_w), .data(wr_data), .done(done_w),
    .par_bad(par_bad), .par_unk(par_unk), .ev_rd(ev_rd), .rd_unk(rd_unk),
    .rd_clr(rd_clr), .cfg_q(cfg_o), .act_q(act_time_o), .dbn_q(debounce_o),
    .ksz_q(kp_size_o), .clk_q(clk_cfg_o), .pull_q(gpio_pull_o),
    .dir_q(gpio_dir_o), .state_q(gpio_state_o), .status_q(status_w),
    .err_q(err_w), .irq_n(irq_n), .flush(queue_flush)
  );

  kpc_resp #(.IDX_W(IDX_W), .GPIO_W(GPIO_W), .ID_VAL(ID_VAL)) u_resp (
    .clk(clk), .rst(rst), .ev_rd(ev_rd), .cmd(cmd_w), .idx(idx_w),
    .cfg_q(cfg_o), .ksz_q(kp_size_o), .clk_q(clk_cfg_o), .dir_q(gpio_dir_o),
    .state_q(gpio_state_o), .status_q(status_w), .err_q(err_w),
    .rd_unk(rd_unk), .rd_clr(rd_clr), .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/kpc_cmd_ctrl_chk.sv
module kpc_cmd_ctrl_chk #(
  parameter logic [7:0] CFG_RST = 8'h80
) (
  input logic       clk,
  input logic       rst,
  input logic       txn_start,
  input logic       wr_valid,
  input logic       rd_req,
  input logic       rd_valid,
  input logic       irq_n,
  input logic [7:0] cfg_o,
  input logic [7:0] status,
  input logic [7:0] err
);
  // R12
  irq_tracks_status_chk: assert property (@(posedge clk) disable iff (rst)
    irq_n == (status == 8'h00));

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err & $past(err)) == $past(err));

  // R11
  err_sets_status_chk: assert property (@(posedge clk) disable iff (rst)
    (err != $past(err)) |-> status[3]);

  // R13
  rd_resp_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !txn_start && !wr_valid) |=> rd_valid);

  // R13
  rd_valid_src_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_req));

  // R1
  reset_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg_o == CFG_RST && status == 8'h10));
endmodule

bind kpc_cmd_ctrl kpc_cmd_ctrl_chk #(.CFG_RST(CFG_RST)) u_bind_chk (
  .clk(clk), .rst(rst), .txn_start(txn_start), .wr_valid(wr_valid),
  .rd_req(rd_req), .rd_valid(rd_valid), .irq_n(irq_n), .cfg_o(cfg_o),
  .status(status_w), .err(err_w)
);

// File: tb/test_kpc_cmd_ctrl.sv
`timescale 1ns/1ps
module test_kpc_cmd_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        txn_start = 1'b0, txn_write = 1'b0, wr_valid = 1'b0, rd_req = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic [7:0]  rd_data, cfg_o, act_time_o, debounce_o, kp_size_o, clk_cfg_o;
  logic        rd_valid, irq_n, queue_flush;
  logic [15:0] gpio_pull_o, gpio_dir_o, gpio_state_o;

  int compared = 0, mismatched = 0;
  logic flush_seen;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  kpc_cmd_ctrl i_kpc_cmd_ctrl (
    .clk(clk), .rst(rst), .txn_start(txn_start), .txn_write(txn_write),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req),
    .rd_data(rd_data), .rd_valid(rd_valid), .irq_n(irq_n), .cfg_o(cfg_o),
    .act_time_o(act_time_o), .debounce_o(debounce_o), .kp_size_o(kp_size_o),
    .clk_cfg_o(clk_cfg_o), .gpio_pull_o(gpio_pull_o), .gpio_dir_o(gpio_dir_o),
    .gpio_state_o(gpio_state_o), .queue_flush(queue_flush)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic hard_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic start(input logic dir);
    @(negedge clk); txn_start = 1'b1; txn_write = dir;
    @(negedge clk); txn_start = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] b);
    @(negedge clk); wr_valid = 1'b1; wr_data = b;
    @(negedge clk); wr_valid = 1'b0; flush_seen = queue_flush;
  endtask

  task automatic rd_byte(output logic [7:0] b);
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    check("R13 rd_valid", {15'd0, rd_valid}, 16'd1);
    b = rd_data;
  endtask

  task automatic wcmd1(input logic [7:0] c, input logic [7:0] p);
    start(1'b1); wr_byte(c); wr_byte(p);
  endtask

  task automatic read1(input logic [7:0] c, output logic [7:0] b);
    start(1'b1); wr_byte(c); start(1'b0); rd_byte(b);
  endtask

  task automatic init_cfg();
    hard_reset(); wcmd1(8'h81, 8'h00);
  endtask

  task automatic t_reset();
    hard_reset();
    check("R1 cfg", cfg_o, 16'h80);
    check("R1 act", act_time_o, 16'd125);
    check("R1 dbn", debounce_o, 16'd3);
    check("R1 ksz", kp_size_o, 16'h33);
    check("R1 clk", clk_cfg_o, 16'h08);
    check("R1 gpio", gpio_dir_o | gpio_pull_o | gpio_state_o, 16'h0);
    check("R1 irq_n", {15'd0, irq_n}, 16'd0);
    read1(8'h82, rv); check("R1/R5 status", rv, 16'h10);
    rd_byte(rv);       check("R5 noinit keeps status", rv, 16'h10);
    read1(8'h8C, rv);  check("R1 error", rv, 16'h00);
  endtask

  task automatic t_id();
    hard_reset();
    start(1'b1); wr_byte(8'h80); start(1'b0);
    rd_byte(rv); check("R3 id b0", rv, 16'h00);
    rd_byte(rv); check("R3 id b1", rv, 16'h04);
    rd_byte(rv); check("R3 id b2", rv, 16'h00);
  endtask

  task automatic t_cfg();
    hard_reset();
    wcmd1(8'h81, 8'h05);
    check("R6 flush", {15'd0, flush_seen}, 16'd1);
    check("R6 cfg", cfg_o, 16'h05);
    check("R12 irq_n high", {15'd0, irq_n}, 16'd1);
    @(negedge clk); check("R6 flush one cycle", {15'd0, queue_flush}, 16'd0);
    wcmd1(8'h81, 8'hF3);
    read1(8'h92, rv); check("R6 cfg nibble", rv, 16'h03);
    read1(8'h82, rv); check("R6 status cleared", rv, 16'h00);
  endtask

  task automatic t_err_status();
    init_cfg();
    wcmd1(8'h8F, 8'h00);
    check("R8 dbn stored", debounce_o, 16'h00);
    check("R12 irq_n low", {15'd0, irq_n}, 16'd0);
    read1(8'h8C, rv); check("R8 dbn zero bad", rv, 16'h01);
    read1(8'h82, rv); check("R11 status bit3", rv, 16'h08);
    rd_byte(rv);       check("R5 status cleared", rv, 16'h00);
    check("R12 irq_n back high", {15'd0, irq_n}, 16'd1);
    read1(8'h8C, rv); check("R11 sticky", rv, 16'h01);
  endtask

  task automatic t_ksz();
    init_cfg();
    wcmd1(8'h90, 8'h3C);
    wcmd1(8'h90, 8'h83);
    read1(8'h8C, rv); check("R7 legal bounds", rv, 16'h00);
    wcmd1(8'h90, 8'h92);
    read1(8'h91, rv); check("R7 stored", rv, 16'h92);
    read1(8'h8C, rv); check("R7 bad size", rv, 16'h01);
    init_cfg();
    wcmd1(8'h90, 8'hC3);
    read1(8'h8C, rv); check("R7 cols high", rv, 16'h01);
  endtask

  task automatic t_clk();
    init_cfg();
    wcmd1(8'h93, 8'h03);
    check("R8 clk out", clk_cfg_o, 16'h03);
    read1(8'h94, rv); check("R8 clk read", rv, 16'h02);
    read1(8'h8C, rv); check("R8 clk 11 ok", rv, 16'h00);
    wcmd1(8'h93, 8'hF1);
    read1(8'h94, rv); check("R8 clk read2", rv, 16'hF2);
    read1(8'h8C, rv); check("R8 clk 01 bad", rv, 16'h01);
  endtask

  task automatic t_gpio();
    init_cfg();
    wcmd1(8'h84, 8'h0F); wr_byte(8'hF0);
    check("R4 pull", gpio_pull_o, 16'hF00F);
    start(1'b1); wr_byte(8'h85); wr_byte(8'h34); wr_byte(8'h12);
    check("R4 dir", gpio_dir_o, 16'h1234);
    start(1'b1); wr_byte(8'h86); wr_byte(8'hAB);
    check("R4 state low clears high", gpio_state_o, 16'h00AB);
    wr_byte(8'hCD);
    check("R4 state", gpio_state_o, 16'hCDAB);
    start(1'b1); wr_byte(8'h87); start(1'b0);
    rd_byte(rv); check("R4 dir lo", rv, 16'h34);
    rd_byte(rv); check("R4 dir hi", rv, 16'h12);
    read1(8'h88, rv); check("R4 state lo", rv, 16'hAB);
    read1(8'h8C, rv); check("R4 no error", rv, 16'h00);
    start(1'b1); wr_byte(8'h85); wr_byte(8'h01); wr_byte(8'h02); wr_byte(8'h03);
    check("R10 dir unchanged", gpio_dir_o, 16'h0201);
    read1(8'h8C, rv); check("R10 extra byte", rv, 16'h01);
  endtask

  task automatic t_softreset();
    init_cfg();
    wcmd1(8'h81, 8'h05);
    wcmd1(8'h8B, 8'h20);
    check("R14 act", act_time_o, 16'h20);
    read1(8'h8C, rv); check("R14 no error", rv, 16'h00);
    start(1'b1); wr_byte(8'h85); wr_byte(8'h11); wr_byte(8'h22);
    wcmd1(8'h83, 8'h55);
    check("R9 bad key keeps cfg", cfg_o, 16'h05);
    read1(8'h8C, rv); check("R9 bad key", rv, 16'h01);
    wcmd1(8'h83, 8'hAA);
    check("R9 cfg", cfg_o, 16'h80);
    check("R9 act", act_time_o, 16'd125);
    check("R9 gpio kept", gpio_dir_o, 16'h2211);
    check("R9 irq_n", {15'd0, irq_n}, 16'd0);
    read1(8'h82, rv); check("R9 status", rv, 16'h10);
    rd_byte(rv);       check("R9/R5 noinit hold", rv, 16'h10);
    read1(8'h8C, rv); check("R9 error kept", rv, 16'h01);
  endtask

  task automatic t_unknown();
    init_cfg();
    start(1'b1); wr_byte(8'h99);
    read1(8'h8C, rv); check("R2 unknown code", rv, 16'h02);
    init_cfg();
    start(1'b1); wr_byte(8'h8B); start(1'b0); rd_byte(rv);
    check("R2 read of write cmd", rv, 16'h00);
    read1(8'h8C, rv); check("R2 read of write cmd err", rv, 16'h02);
    init_cfg();
    wcmd1(8'h80, 8'h12);
    read1(8'h8C, rv); check("R2 param to read cmd", rv, 16'h02);
    hard_reset();
    wr_byte(8'h77);
    read1(8'h8C, rv); check("R10 no command", rv, 16'h01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    t_reset();
    t_id();
    t_cfg();
    t_err_status();
    t_ksz();
    t_clk();
    t_gpio();
    t_softreset();
    t_unknown();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule